// File: doc/BRIEF.md
# I2C-Controlled Two-Channel Bus Selector

This block is the control side of a two-channel downstream bus switch. It behaves as an I2C target: it samples the upstream SCL and SDA lines with the system clock, recognises START and STOP, compares the address byte against its own address, and drives an open-drain pull-low enable onto SDA for acknowledges and read data. Written bytes land in a small control register. The two low bits of that register select which downstream channels are connected. Either channel, both, or neither may be selected.

A newly written selection reaches the channel-enable outputs only when a STOP appears on the bus. Channels therefore never switch in the middle of a transfer. Two active-low interrupt lines, one per channel, are combined into a single active-low interrupt output. A register read reports the live state of those lines, so the host can find which channel raised the request. The active-low reset input brings the block back to idle with both channels off. It is used to recover a downstream bus that is stuck low.

Top module: `i2c_chan_switch`

## Requirements
- R1: The block acknowledges, by pulling SDA low during the ninth clock, an address byte whose upper seven bits are 1110 0 followed by `addr_pins_i[1]` and `addr_pins_i[0]`. The parameter `ALT_ADDR`=1 changes the fixed part to 11110. Bit 0 of the address byte is 1 for a read and 0 for a write.
- R2: An address byte that does not match gets no acknowledge. The rest of that transfer is ignored, and the register and channel outputs keep their values.
- R3: In a write, every data byte is acknowledged. When several bytes are sent in one transfer, only the last one stays in the register.
- R4: `chan_en_o[0]` follows register bit 0 and `chan_en_o[1]` follows register bit 1. They change only when a STOP is seen, never at the write itself.
- R5: A read returns one byte, most significant bit first. Bits 7 and 6 are 0. Bit 5 is the inverse of `irq_n_i[1]` and bit 4 is the inverse of `irq_n_i[0]`, sampled live. Bits 3 to 0 are the last written value.
- R6: In a read, the master's acknowledge causes the same byte to be sent again. The master's NACK makes the block release SDA until the next START. SDA is pulled only in acknowledge and read-data slots.
- R7: `irq_n_o` is low whenever either interrupt input is low. It is the AND of the two inputs.
- R8: While `rst_n` is low, the register is cleared, both channels are off, SDA is released, and the bus logic returns to idle.
- R9: A START that arrives in the middle of a transfer restarts address reception. SDA changes while SCL is high are never taken as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Upstream serial clock level |
| sda_i | input | 1 | Upstream serial data level |
| addr_pins_i | input | 2 | Strap pins forming the low two address bits |
| irq_n_i | input | 2 | Active-low interrupt request per channel |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| chan_en_o | output | 2 | Downstream channel connect enables |
| irq_n_o | output | 1 | Active-low combined interrupt |

## Verification
The bench checks the channel outputs just before and just after each STOP. A design that applied a selection at the write would switch a channel in the middle of a transfer. It sends several data bytes in one transfer: a design keeping the first byte would select the wrong channels. It sends an address with the wrong strap bits, to catch a design that acknowledges a foreign address. It uses a repeated START and a read with master ACK then NACK, to catch designs that lose the restart or keep driving SDA after the NACK. Reset is pulsed mid-transfer, to catch a design that leaves a channel on.

// File: rtl/i2c_chan_switch.sv
module i2c_chan_switch #(
  parameter bit ALT_ADDR = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_pins_i,
  input  logic [1:0] irq_n_i,
  output logic       sda_pull_o,
  output logic [1:0] chan_en_o,
  output logic       irq_n_o
);
  localparam logic [4:0] FIXED = ALT_ADDR ? 5'b11110 : 5'b11100;
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_AACK = 3'd2, S_WDAT = 3'd3,
                         S_WACK = 3'd4, S_RDAT = 3'd5, S_RACK = 3'd6;

  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  logic [2:0] st;
  logic [3:0] cnt;
  logic [7:0] sr;
  logic [3:0] ctrl;
  logic       rw;

  wire scl_s    = scl_q[1];
  wire sda_s    = sda_q[1];
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire [7:0] rd_byte = {2'b00, ~irq_n_i[1], ~irq_n_i[0], ctrl};

  assign irq_n_o = &irq_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      sr         <= '0;
      ctrl       <= '0;
      rw         <= 1'b0;
      sda_pull_o <= 1'b0;
      chan_en_o  <= '0;
    end else if (start_c) begin
      st         <= S_ADDR;
      cnt        <= '0;
      sda_pull_o <= 1'b0;
    end else if (stop_c) begin
      st         <= S_IDLE;
      sda_pull_o <= 1'b0;
      chan_en_o  <= ctrl[1:0];
    end else begin
      case (st)
        S_ADDR, S_WDAT: begin
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (st == S_WDAT) begin
              ctrl       <= sr[3:0];
              sda_pull_o <= 1'b1;
              st         <= S_WACK;
            end else if (sr[7:1] == {FIXED, addr_pins_i}) begin
              rw         <= sr[0];
              sda_pull_o <= 1'b1;
              st         <= S_AACK;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_AACK, S_RACK: begin
          if (st == S_RACK && scl_rise && sda_s) begin
            st <= S_IDLE;
          end else if (scl_fall) begin
            cnt <= '0;
            if (st == S_RACK || rw) begin
              sda_pull_o <= ~rd_byte[7];
              sr         <= {rd_byte[6:0], 1'b0};
              st         <= S_RDAT;
            end else begin
              sda_pull_o <= 1'b0;
              st         <= S_WDAT;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            sda_pull_o <= 1'b0;
            cnt        <= '0;
            st         <= S_WDAT;
          end
        end
        S_RDAT: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_pull_o <= 1'b0;
              st         <= S_RACK;
            end else begin
              sda_pull_o <= ~sr[7];
              sr         <= {sr[6:0], 1'b0};
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module i2c_chan_switch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] irq_n_i,
  input logic       irq_n_o,
  input logic [1:0] chan_en_o,
  input logic       sda_pull_o,
  input logic       start_c,
  input logic       stop_c,
  input logic [2:0] st
);
  localparam logic [2:0] C_IDLE = 3'd0, C_ADDR = 3'd1, C_AACK = 3'd2,
                         C_WACK = 3'd4, C_RDAT = 3'd5;

  // R7
  irq_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o == (irq_n_i[0] & irq_n_i[1]));

  // R4
  chan_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en_o) |-> $past(stop_c));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> st == C_ADDR);

  // R6
  pull_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (st == C_AACK || st == C_WACK || st == C_RDAT));

  // R8
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (chan_en_o == 2'b00 && !sda_pull_o && st == C_IDLE));
endmodule

bind i2c_chan_switch i2c_chan_switch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n_i), .irq_n_o(irq_n_o),
  .chan_en_o(chan_en_o), .sda_pull_o(sda_pull_o), .start_c(start_c),
  .stop_c(stop_c), .st(st)
);

// File: tb/i2c_chan_switch_bench.sv
module i2c_chan_switch_bench;
  localparam time T = 80ns;
  // {pins, irq_n, write byte, expected read byte, expected channels}
  localparam logic [21:0] VEC [6] = '{
    {2'b00, 2'b11, 8'h01, 8'h01, 2'b01},
    {2'b01, 2'b10, 8'h02, 8'h12, 2'b10},
    {2'b10, 2'b01, 8'hFF, 8'h2F, 2'b11},
    {2'b11, 2'b00, 8'h0C, 8'h3C, 2'b00},
    {2'b00, 2'b11, 8'h33, 8'h03, 2'b11},
    {2'b11, 2'b11, 8'hA6, 8'h06, 2'b10}
  };

  logic clk = 1'b0;
  always #4ns clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] pins = 2'b00, irq = 2'b11;
  logic       sda_pull, irq_o;
  logic [1:0] chan;
  wire        sda_bus = sda_m & ~sda_pull;
  int total = 0, bad = 0;
  bit done = 1'b0;

  i2c_chan_switch u_i2c_chan_switch (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_pins_i(pins), .irq_n_i(irq), .sda_pull_o(sda_pull),
    .chan_en_o(chan), .irq_n_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #(T); scl_m = 1'b1; #(T); sda_m = 1'b0; #(T); scl_m = 1'b0; #(T);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #(T); scl_m = 1'b1; #(T); sda_m = 1'b1; #(T);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #(T); scl_m = 1'b1; #(T); scl_m = 1'b0;
    end
    sda_m = 1'b1; #(T); scl_m = 1'b1; #(T/2); ack = ~sda_bus; #(T/2); scl_m = 1'b0;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #(T); scl_m = 1'b1; #(T/2); b[i] = sda_bus; #(T/2); scl_m = 1'b0;
    end
    sda_m = ~mack; #(T); scl_m = 1'b1; #(T); scl_m = 1'b0; sda_m = 1'b1;
  endtask

  task automatic read_reg(input logic [1:0] p, output logic [7:0] b);
    logic a;
    bus_start();
    send_byte({5'b11100, p, 1'b1}, a);
    chk("R1 read address ack", a, 1);
    read_byte(1'b0, b);
    bus_stop();
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] rb;
    logic [1:0] prev;
    #1ns;
    #(T);
    // R8 outputs while reset held
    chk("R8 chan in reset", chan, 2'b00);
    chk("R8 pull in reset", sda_pull, 0);
    rst_n = 1'b1;
    #(T);
    chk("R8 chan after reset", chan, 2'b00);
    chk("R7 irq idle", irq_o, 1);

    prev = 2'b00;
    for (int i = 0; i < 6; i++) begin
      pins = VEC[i][21:20];
      irq  = VEC[i][19:18];
      #(T);
      chk("R7 irq combine", irq_o, &VEC[i][19:18]);
      bus_start();
      send_byte({5'b11100, pins, 1'b0}, a);
      chk("R1 write address ack", a, 1);
      send_byte(VEC[i][17:10], a);
      chk("R3 data ack", a, 1);
      chk("R4 chan held before stop", chan, prev);
      bus_stop();
      chk("R4 chan after stop", chan, VEC[i][1:0]);
      read_reg(pins, rb);
      chk("R5 read byte", rb, VEC[i][9:2]);
      chk("R6 released after read", sda_pull, 0);
      prev = VEC[i][1:0];
    end

    // R3 several bytes, last kept
    pins = 2'b00; irq = 2'b11;
    bus_start();
    send_byte(8'hE0, a);
    send_byte(8'h01, a);
    send_byte(8'h02, a);
    send_byte(8'h03, a);
    chk("R3 third byte ack", a, 1);
    bus_stop();
    chk("R3 last byte selects", chan, 2'b11);

    // R2 foreign address
    bus_start();
    send_byte(8'hE2, a);
    chk("R2 no ack on mismatch", a, 0);
    send_byte(8'h00, a);
    chk("R2 data ignored no ack", a, 0);
    bus_stop();
    chk("R2 chan unchanged", chan, 2'b11);
    read_reg(2'b00, rb);
    chk("R2 register unchanged", rb, 8'h03);

    // R9 repeated start into read
    bus_start();
    send_byte(8'hE0, a);
    send_byte(8'h02, a);
    bus_start();
    send_byte(8'hE1, a);
    chk("R9 ack after restart", a, 1);
    read_byte(1'b1, rb);
    chk("R9 read after restart", rb, 8'h02);
    // R6 master ack then nack
    read_byte(1'b0, rb);
    chk("R6 repeated byte", rb, 8'h02);
    #(T);
    chk("R6 SDA released after nack", sda_pull, 0);
    bus_stop();
    chk("R4 chan after restart stop", chan, 2'b10);

    // R8 reset in mid-transfer
    bus_start();
    send_byte(8'hE0, a);
    send_byte(8'h03, a);
    bus_stop();
    chk("R8 chan before reset", chan, 2'b11);
    bus_start();
    send_byte(8'hE0, a);
    rst_n = 1'b0;
    #(T);
    chk("R8 chan cleared", chan, 2'b00);
    chk("R8 SDA released", sda_pull, 0);
    scl_m = 1'b1; sda_m = 1'b1;
    #(T);
    rst_n = 1'b1;
    #(T);
    scl_m = 1'b0; sda_m = 1'b0; #(T); scl_m = 1'b1; #(T); sda_m = 1'b1; #(T);
    read_reg(2'b00, rb);
    chk("R8 register cleared", rb, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule